// File: doc/BRIEF.md
# Segment-and-Page Translation Cache

This block caches recent address translations for a memory scheme that applies segmentation and then paging. Each logical address is 34 bits wide. The top 18 bits give the segment number, which is itself made of an 8-bit major field above a 10-bit minor field. Below that sit a 6-bit page number and a 10-bit word offset, so each page holds 1K words. The segment number and the page number together form a 24-bit key, and the cache keeps one 14-bit frame number for each key. There are 16 entries, and any key can sit in any of them.

A lookup takes one cycle. On a hit, the frame number takes the place of the segment and page fields, and the word offset passes through unchanged to form a 24-bit physical address. On a miss, the block reports the key, and an outside walker that reads the segment and page tables supplies the result through the fill port. A flush input empties the whole cache.

Top module: `segpage_xlat_cache`

## Requirements
- R1: The lookup key is `lk_addr[33:10]`, which is the 8-bit major segment, the 10-bit minor segment and the 6-bit page, from the top down. The word offset is `lk_addr[9:0]`. Keys that differ in any one of these fields are distinct entries.
- R2: A lookup with `lk_valid` high gives a response on the next cycle with `rsp_valid` high. If the key is cached, `rsp_hit` is 1 and `rsp_paddr` is {frame[13:0], offset[9:0]}.
- R3: If a looked-up key is not cached, the response has `rsp_miss` = 1, `rsp_hit` = 0, `rsp_miss_key` = the 24-bit key and `rsp_paddr` = 0. `rsp_hit` and `rsp_miss` are never high together. Both are low whenever `rsp_valid` is low.
- R4: A fill whose key is not already cached goes into the lowest-numbered invalid entry whenever at least one entry is invalid.
- R5: When all entries are valid, a fill of a new key replaces the entry chosen by a round-robin pointer. The pointer is 0 after reset and steps by one, wrapping modulo 16, only on such a replacement. The replaced key then misses.
- R6: A fill of a key that is already cached overwrites that entry's frame and does not take a second entry.
- R7: `flush` invalidates every entry. A lookup in the same cycle as `flush` reports a miss, and a fill in the same cycle as `flush` is dropped.
- R8: After reset, `rsp_valid`, `rsp_hit` and `rsp_miss` are 0 and no entry is valid.
- R9: A lookup in the same cycle as a fill sees the contents from before that fill.
- R10: Sixteen distinct keys can be resident at once, and all of them hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 34 | Logical address to translate |
| fill_valid | input | 1 | Write a translation |
| fill_key | input | 24 | Segment-and-page key for the fill |
| fill_frame | input | 14 | Frame number for the fill |
| rsp_valid | output | 1 | Response for the previous cycle's lookup |
| rsp_hit | output | 1 | Translation found |
| rsp_miss | output | 1 | Translation absent |
| rsp_paddr | output | 24 | Physical address on a hit, otherwise 0 |
| rsp_miss_key | output | 24 | Key that missed, otherwise 0 |

## Verification
A corrupted valid bit or key shows up on the very next lookup of that key, either as a false hit or as a miss that reports the key. A wrong frame shows up at once in the upper 14 bits of `rsp_paddr`. Faults in victim selection do not show until later. A fill that lands on the wrong entry, or a round-robin pointer that steps at the wrong time, stays hidden until a key that should still be resident misses. For that reason, the bench fills the cache to capacity and then evicts in sequence, which makes such a fault visible within a few lookups.

// File: rtl/segpage_xlat_pkg.sv
package segpage_xlat_pkg;
    localparam int SEG_MAJ_W = 8;
    localparam int SEG_MIN_W = 10;
    localparam int PAGE_W    = 6;
    localparam int WORD_W    = 10;
    localparam int FRAME_W   = 14;
    localparam int N_ENTRIES = 16;

    localparam int SEG_W   = SEG_MAJ_W + SEG_MIN_W;
    localparam int KEY_W   = SEG_W + PAGE_W;
    localparam int LADDR_W = KEY_W + WORD_W;
    localparam int PADDR_W = FRAME_W + WORD_W;

    typedef logic [KEY_W-1:0]   key_t;
    typedef logic [FRAME_W-1:0] frame_t;
    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [PADDR_W-1:0] paddr_t;

    typedef struct packed {
        logic [SEG_MAJ_W-1:0] seg_major;
        logic [SEG_MIN_W-1:0] seg_minor;
        logic [PAGE_W-1:0]    page;
        word_t                word;
    } laddr_t;

    typedef struct packed {
        logic   valid;
        key_t   key;
        frame_t frame;
    } entry_t;

    typedef struct packed {
        logic   valid;
        logic   hit;
        logic   miss;
        paddr_t paddr;
        key_t   miss_key;
    } rsp_t;

    function automatic key_t key_of(laddr_t a);
        return {a.seg_major, a.seg_minor, a.page};
    endfunction
endpackage

// File: rtl/xlat_entry_array.sv
module xlat_entry_array
    import segpage_xlat_pkg::*;
#(
    parameter int N  = N_ENTRIES,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  key_t          lk_key,
    output logic          lk_hit,
    output frame_t        lk_frame,
    input  key_t          fl_key,
    output logic          fl_hit,
    output logic [IW-1:0] fl_idx,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  frame_t        wr_frame,
    output logic [N-1:0]  valid_vec
);
    logic [N-1:0] lk_match;
    logic [N-1:0] fl_match;
    frame_t       frames [N];

    for (genvar g = 0; g < N; g++) begin : g_ent
        entry_t ent_q;
        always_ff @(posedge clk) begin
            if (rst || flush) begin
                ent_q <= '0;
            end else if (wr_en && wr_idx == IW'(g)) begin
                ent_q <= '{valid: 1'b1, key: fl_key, frame: wr_frame};
            end
        end
        assign valid_vec[g] = ent_q.valid;
        assign lk_match[g]  = ent_q.valid && (ent_q.key == lk_key);
        assign fl_match[g]  = ent_q.valid && (ent_q.key == fl_key);
        assign frames[g]    = ent_q.frame;
    end

    always_comb begin
        lk_frame = '0;
        fl_idx   = '0;
        for (int i = 0; i < N; i++) begin
            if (lk_match[i]) lk_frame = lk_frame | frames[i];
            if (fl_match[i]) fl_idx = IW'(i);
        end
    end

    assign lk_hit = |lk_match;
    assign fl_hit = |fl_match;

    // R6
    unique_key_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_match) && $onehot0(fl_match));

    // R7
    flush_clears_chk: assert property (@(posedge clk) disable iff (rst)
        $past(flush) && $past(!rst) |-> valid_vec == '0);
endmodule

// File: rtl/xlat_victim_sel.sv
module xlat_victim_sel
    import segpage_xlat_pkg::*;
#(
    parameter int N  = N_ENTRIES,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  valid_vec,
    input  logic          alloc,
    output logic [IW-1:0] victim_idx,
    output logic          full
);
    localparam logic [IW-1:0] LAST = IW'(N - 1);

    logic [IW-1:0] ptr_q;
    logic [IW-1:0] free_idx;

    always_comb begin
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid_vec[i]) free_idx = IW'(i);
        end
    end

    assign full       = &valid_vec;
    assign victim_idx = full ? ptr_q : free_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (alloc && full) begin
            ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        end
    end

    // R5
    rr_step_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) && !$stable(ptr_q) |-> $past(alloc && full));

    // R4
    free_first_chk: assert property (@(posedge clk) disable iff (rst)
        !full |-> !valid_vec[victim_idx]);
endmodule

// File: rtl/segpage_xlat_cache.sv
module segpage_xlat_cache
    import segpage_xlat_pkg::*;
#(
    parameter int N_ENT = N_ENTRIES,
    parameter int IW    = $clog2(N_ENT)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 flush,
    input  logic                 lk_valid,
    input  logic [LADDR_W-1:0]   lk_addr,
    input  logic                 fill_valid,
    input  logic [KEY_W-1:0]     fill_key,
    input  logic [FRAME_W-1:0]   fill_frame,
    output logic                 rsp_valid,
    output logic                 rsp_hit,
    output logic                 rsp_miss,
    output logic [PADDR_W-1:0]   rsp_paddr,
    output logic [KEY_W-1:0]     rsp_miss_key
);
    laddr_t        la;
    key_t          lk_key;
    logic          arr_hit;
    frame_t        arr_frame;
    logic          fl_hit;
    logic [IW-1:0] fl_idx;
    logic [IW-1:0] victim_idx;
    logic [IW-1:0] wr_idx;
    logic [N_ENT-1:0] valid_vec;
    logic          full;
    logic          fill_acc;
    logic          alloc_new;
    logic          hit_now;
    rsp_t          rsp_q;

    assign la     = laddr_t'(lk_addr);
    assign lk_key = key_of(la);

    assign fill_acc  = fill_valid && !flush;
    assign alloc_new = fill_acc && !fl_hit;
    assign wr_idx    = fl_hit ? fl_idx : victim_idx;

    xlat_entry_array #(.N(N_ENT), .IW(IW)) u_array (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .lk_key    (lk_key),
        .lk_hit    (arr_hit),
        .lk_frame  (arr_frame),
        .fl_key    (fill_key),
        .fl_hit    (fl_hit),
        .fl_idx    (fl_idx),
        .wr_en     (fill_acc),
        .wr_idx    (wr_idx),
        .wr_frame  (fill_frame),
        .valid_vec (valid_vec)
    );

    xlat_victim_sel #(.N(N_ENT), .IW(IW)) u_victim (
        .clk        (clk),
        .rst        (rst),
        .valid_vec  (valid_vec),
        .alloc      (alloc_new),
        .victim_idx (victim_idx),
        .full       (full)
    );

    assign hit_now = lk_valid && arr_hit && !flush;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q.valid    <= lk_valid;
            rsp_q.hit      <= hit_now;
            rsp_q.miss     <= lk_valid && !hit_now;
            rsp_q.paddr    <= hit_now ? {arr_frame, la.word} : '0;
            rsp_q.miss_key <= (lk_valid && !hit_now) ? lk_key : '0;
        end
    end

    assign rsp_valid    = rsp_q.valid;
    assign rsp_hit      = rsp_q.hit;
    assign rsp_miss     = rsp_q.miss;
    assign rsp_paddr    = rsp_q.paddr;
    assign rsp_miss_key = rsp_q.miss_key;

    // R3
    hit_miss_excl_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid ? (rsp_hit ^ rsp_miss) : !(rsp_hit || rsp_miss));

    // R7
    flush_lookup_miss_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) && $past(lk_valid && flush) |-> !rsp_hit);

    // R2
    offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) && rsp_hit |-> rsp_paddr[WORD_W-1:0] == $past(lk_addr[WORD_W-1:0]));

    // R3
    miss_key_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) && rsp_miss |-> rsp_miss_key == $past(lk_addr[LADDR_W-1:WORD_W]) && rsp_paddr == '0);
endmodule

// File: tb/segpage_xlat_cache_tb.sv
`timescale 1ns/1ps
module segpage_xlat_cache_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush = 1'b0;
    logic        lk_valid = 1'b0;
    logic [33:0] lk_addr = '0;
    logic        fill_valid = 1'b0;
    logic [23:0] fill_key = '0;
    logic [13:0] fill_frame = '0;
    logic        rsp_valid, rsp_hit, rsp_miss;
    logic [23:0] rsp_paddr, rsp_miss_key;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    segpage_xlat_cache dut_i (
        .clk(clk), .rst(rst), .flush(flush),
        .lk_valid(lk_valid), .lk_addr(lk_addr),
        .fill_valid(fill_valid), .fill_key(fill_key), .fill_frame(fill_frame),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_paddr(rsp_paddr), .rsp_miss_key(rsp_miss_key)
    );

    // vector: {op[1:0], key[23:0], off[9:0], frame[13:0], exp_hit, exp_paddr[23:0]}
    // op 0 lookup, 1 fill, 2 flush
    localparam int NV = 16;
    localparam logic [74:0] VEC [NV] = '{
        {2'd0, 24'h123456, 10'h3FF, 14'h0000, 1'b0, 24'h000000},
        {2'd1, 24'h123456, 10'h000, 14'h0ABC, 1'b0, 24'h000000},
        {2'd0, 24'h123456, 10'h3FF, 14'h0000, 1'b1, {14'h0ABC, 10'h3FF}},
        {2'd0, 24'h923456, 10'h001, 14'h0000, 1'b0, 24'h000000},
        {2'd1, 24'h923456, 10'h000, 14'h1111, 1'b0, 24'h000000},
        {2'd0, 24'h923456, 10'h001, 14'h0000, 1'b1, {14'h1111, 10'h001}},
        {2'd0, 24'h123456, 10'h000, 14'h0000, 1'b1, {14'h0ABC, 10'h000}},
        {2'd0, 24'h123496, 10'h155, 14'h0000, 1'b0, 24'h000000},
        {2'd1, 24'h123496, 10'h000, 14'h3FFF, 1'b0, 24'h000000},
        {2'd0, 24'h123496, 10'h155, 14'h0000, 1'b1, {14'h3FFF, 10'h155}},
        {2'd0, 24'h123457, 10'h2AA, 14'h0000, 1'b0, 24'h000000},
        {2'd1, 24'h123456, 10'h000, 14'h0002, 1'b0, 24'h000000},
        {2'd0, 24'h123456, 10'h123, 14'h0000, 1'b1, {14'h0002, 10'h123}},
        {2'd2, 24'h000000, 10'h000, 14'h0000, 1'b0, 24'h000000},
        {2'd0, 24'h123496, 10'h155, 14'h0000, 1'b0, 24'h000000},
        {2'd0, 24'h123456, 10'h123, 14'h0000, 1'b0, 24'h000000}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Drive one cycle of stimulus at a falling edge, then return at the next
    // falling edge with the inputs cleared and the response settled.
    task automatic step(input bit lv, input logic [33:0] la, input bit fv,
                        input logic [23:0] fk, input logic [13:0] ff, input bit fl);
        lk_valid = lv; lk_addr = la; fill_valid = fv;
        fill_key = fk; fill_frame = ff; flush = fl;
        @(negedge clk);
        lk_valid = 1'b0; fill_valid = 1'b0; flush = 1'b0;
    endtask

    task automatic expect_hit(input string req, input logic [23:0] paddr);
        check(rsp_valid && rsp_hit && !rsp_miss, req, "hit flags",
              {rsp_valid, rsp_hit, rsp_miss}, 3'b110);
        check(rsp_paddr == paddr, req, "paddr", rsp_paddr, paddr);
    endtask

    task automatic expect_miss(input string req, input logic [23:0] key);
        check(rsp_valid && !rsp_hit && rsp_miss, req, "miss flags",
              {rsp_valid, rsp_hit, rsp_miss}, 3'b101);
        check(rsp_miss_key == key, req, "miss key", rsp_miss_key, key);
        check(rsp_paddr == 24'h0, req, "paddr on miss", rsp_paddr, 24'h0);
    endtask

    task automatic lookup(input logic [23:0] key, input logic [9:0] off);
        step(1'b1, {key, off}, 1'b0, '0, '0, 1'b0);
    endtask

    task automatic fill(input logic [23:0] key, input logic [13:0] fr);
        step(1'b0, '0, 1'b1, key, fr, 1'b0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8: reset state
        check(!rsp_valid && !rsp_hit && !rsp_miss, "R8", "reset flags",
              {rsp_valid, rsp_hit, rsp_miss}, 3'b000);
        lookup(24'h123456, 10'h3FF);
        expect_miss("R8", 24'h123456);

        // R1 R2 R3 R6 R7: table walk
        for (int i = 0; i < NV; i++) begin
            logic [74:0] v;
            v = VEC[i];
            case (v[74:73])
                2'd0: begin
                    lookup(v[72:49], v[48:39]);
                    if (v[24]) expect_hit("R1/R2 table", v[23:0]);
                    else       expect_miss("R1/R3 table", v[72:49]);
                end
                2'd1: begin
                    fill(v[72:49], v[38:25]);
                    check(!rsp_valid, "R6 table", "no response on fill", rsp_valid, 1'b0);
                end
                default: begin
                    step(1'b0, '0, 1'b0, '0, '0, 1'b1);
                    check(!rsp_valid, "R7 table", "no response on flush", rsp_valid, 1'b0);
                end
            endcase
        end

        // R7: lookup with flush in the same cycle misses; the entry is gone
        fill(24'h0A0A0A, 14'h0123);
        step(1'b1, {24'h0A0A0A, 10'h011}, 1'b0, '0, '0, 1'b1);
        expect_miss("R7 lookup+flush", 24'h0A0A0A);
        lookup(24'h0A0A0A, 10'h011);
        expect_miss("R7 after flush", 24'h0A0A0A);

        // R7: fill with flush in the same cycle is dropped
        step(1'b0, '0, 1'b1, 24'h0B0B0B, 14'h0456, 1'b1);
        lookup(24'h0B0B0B, 10'h000);
        expect_miss("R7 fill+flush", 24'h0B0B0B);

        // R9: lookup in the same cycle as a fill sees old contents
        step(1'b1, {24'h0C0C0C, 10'h0F0}, 1'b1, 24'h0C0C0C, 14'h0789, 1'b0);
        expect_miss("R9 lookup+fill", 24'h0C0C0C);
        lookup(24'h0C0C0C, 10'h0F0);
        expect_hit("R9 next lookup", {14'h0789, 10'h0F0});

        // R4 R6 R10: refill from empty, with one duplicate fill
        step(1'b0, '0, 1'b0, '0, '0, 1'b1);
        fill(24'h400000, 14'h0EEE);
        fill(24'h400000, 14'h0100);
        for (int k = 1; k < 16; k++) fill(24'h400000 + 24'(k), 14'h0100 + 14'(k));
        for (int k = 0; k < 16; k++) begin
            lookup(24'h400000 + 24'(k), 10'(k));
            expect_hit("R10/R6/R4 resident", {14'h0100 + 14'(k), 10'(k)});
        end

        // R5: round-robin replacement starting at entry 0
        fill(24'h500000, 14'h2000);
        lookup(24'h400000, 10'h000);
        expect_miss("R5 first victim", 24'h400000);
        lookup(24'h400001, 10'h001);
        expect_hit("R5 neighbour kept", {14'h0101, 10'h001});
        lookup(24'h500000, 10'h3C3);
        expect_hit("R5 new entry", {14'h2000, 10'h3C3});
        fill(24'h500001, 14'h2001);
        lookup(24'h400001, 10'h001);
        expect_miss("R5 second victim", 24'h400001);
        lookup(24'h400002, 10'h002);
        expect_hit("R5 third kept", {14'h0102, 10'h002});
        lookup(24'h500000, 10'h000);
        expect_hit("R5 first fill kept", {14'h2000, 10'h000});

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule